// File: doc/BRIEF.md
# XOR-Encoded Multi-Writer Register Memory

This block is a register-array memory that accepts several writes and several reads in every clock cycle. It is built only from storage banks that each take a single write. Every write port owns one bank and writes nothing else. A write does not store its data as given. It stores the data XORed with what all the other write ports' banks currently hold at the same address.

A read fetches that address from every bank and XORs the values together. The other banks' contributions cancel, so the read yields the data of the most recent write to that address, whichever port wrote it. No arbitration and no table of last writers is needed.

Each bank gives combinational access to its array through one tap per external read port and one tap per other write port. The write encoders use the second set of taps. Read results are registered, so data appears one cycle after the request. Two write ports must not target the same address in the same cycle. If they do, the content at that address is undefined until a later single write to it.

Top module: `xor_mwram`

## Requirements
- R1: After a synchronous active-low reset every `rd_data` lane is zero, and every address reads back as zero.
- R2: A read issued in a cycle sets its `rd_data` lane after the next rising edge, to the value most recently written at that address. A write enabled in cycle N is visible to reads issued from cycle N+1 on.
- R3: All write ports may write distinct addresses in the same cycle, and every one of those writes is retained.
- R4: When different write ports write one address in successive cycles, a later read returns the last data written, whichever port wrote it.
- R5: A read and a write to the same address in the same cycle: the read returns the value held before that write (read-before-write).
- R6: Each read port decodes its own address independently of the others, under arbitrary mixes of concurrent non-conflicting writes.
- R7: While `rd_en[j]` is low, lane j of `rd_data` keeps its previous value, even when the stored content of its last address changes.
- R8: A write port whose `wr_en` bit is low changes no stored value, whatever its address and data inputs carry.
- R9: After two write ports hit the same address in one cycle, a single later write to that address restores correct readback there.
- R10: A reset applied during operation clears all previously written content to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all banks and read registers |
| wr_en | input | NW | Write enable, bit k for write port k |
| wr_addr | input | NW*AW | Write addresses, port k in bits [k*AW +: AW] |
| wr_data | input | NW*W | Write data, port k in bits [k*W +: W] |
| rd_en | input | NR | Read enable, bit j for read port j |
| rd_addr | input | NR*AW | Read addresses, port j in bits [j*AW +: AW] |
| rd_data | output | NR*W | Registered read data, port j in bits [j*W +: W] |

## Verification
The only result with its own timing is the read lane. It is due one rising edge after the request, and it reflects every write enabled in earlier cycles but none enabled in the request's own cycle. The driver pushes each expected lane value, stamped with the edge count at which it becomes due, into a queue. The monitor pops the entry on the falling edge after that rising edge. A lane whose port is idle is expected to hold its last value. Addresses left undefined by a deliberate write collision are not checked until a single later write restores them.

// File: rtl/xmw_pkg.sv
// Shared helpers for the XOR-encoded multi-writer memory.
// Assumes the number of write ports is at least two.
package xmw_pkg;

    // Taps each bank needs: one per read port plus one per other writer.
    function automatic int bank_taps(input int n_wr, input int n_rd);
        return n_rd + n_wr - 1;
    endfunction

    // Write port served by the m-th writer tap of bank 'self'.
    function automatic int slot_owner(input int self, input int m);
        return (m < self) ? m : m + 1;
    endfunction

    // Index of writer 'other' among the writer taps of bank 'self'.
    function automatic int other_slot(input int self, input int other);
        return (other < self) ? other : other - 1;
    endfunction

endpackage

// File: rtl/xmw_bank.sv
// One storage bank: a single write port and NT combinational read taps.
// Assumes the address width covers the full depth (2**AW words).
// The synchronous active-low reset clears every word.
module xmw_bank #(
    parameter int W  = 8,
    parameter int AW = 4,
    parameter int NT = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [NT*AW-1:0] taddr,
    output logic [NT*W-1:0]  tdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the encoded word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One combinational read per tap.
    for (genvar t = 0; t < NT; t++) begin : g_tap
        assign tdata[t*W +: W] = mem[taddr[t*AW +: AW]];
    end

endmodule

// File: rtl/xmw_wr_encode.sv
// Write encoder: folds the other banks' words at the write address into
// the incoming data, so that the XOR over all banks equals the new data.
// Assumes NO >= 1 other banks.
module xmw_wr_encode #(
    parameter int W  = 8,
    parameter int NO = 1
) (
    input  logic [W-1:0]    din,
    input  logic [NO*W-1:0] others,
    output logic [W-1:0]    enc
);
    // Running XOR of the incoming data with every other bank's word.
    always_comb begin
        enc = din;
        for (int o = 0; o < NO; o++) begin
            enc = enc ^ others[o*W +: W];
        end
    end

endmodule

// File: rtl/xmw_rd_decode.sv
// Read decoder: XORs one word from every bank and registers the result.
// The output holds while the enable is low and clears on reset.
module xmw_rd_decode #(
    parameter int W  = 8,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NB*W-1:0] taps,
    output logic [W-1:0]    q
);
    logic [W-1:0] mix;

    // Combine the words of all banks.
    always_comb begin
        mix = '0;
        for (int b = 0; b < NB; b++) begin
            mix = mix ^ taps[b*W +: W];
        end
    end

    // Register the decoded word when the port is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= mix;
        end
    end

endmodule

// File: rtl/xor_mwram.sv
// Multi-writer, multi-reader register memory built from one-write banks.
// Each write port owns a bank. A write stores its data XORed with the other
// banks' words at its address. A read XORs all banks and returns the data
// of the latest write to that address. Assumes no two writers hit the same
// address in one cycle. Reads are read-before-write with one cycle latency.
module xor_mwram
    import xmw_pkg::*;
#(
    parameter int NW = 2,
    parameter int NR = 2,
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    wr_en,
    input  logic [NW*AW-1:0] wr_addr,
    input  logic [NW*W-1:0]  wr_data,
    input  logic [NR-1:0]    rd_en,
    input  logic [NR*AW-1:0] rd_addr,
    output logic [NR*W-1:0]  rd_data
);
    localparam int NT = bank_taps(NW, NR);
    localparam int NO = NW - 1;

    logic [NT*AW-1:0] tap_addr [NW];
    logic [NT*W-1:0]  tap_data [NW];
    logic [W-1:0]     enc_data [NW];

    for (genvar k = 0; k < NW; k++) begin : g_bank
        logic [NO*W-1:0] oth;

        // External read ports occupy the first NR taps.
        for (genvar j = 0; j < NR; j++) begin : g_rtap
            assign tap_addr[k][j*AW +: AW] = rd_addr[j*AW +: AW];
        end

        // Remaining taps follow the other writers' addresses.
        for (genvar m = 0; m < NO; m++) begin : g_wtap
            localparam int OWNER = slot_owner(k, m);
            localparam int SLOT  = NR + other_slot(OWNER, k);
            assign tap_addr[k][(NR+m)*AW +: AW] = wr_addr[OWNER*AW +: AW];
            assign oth[m*W +: W] = tap_data[OWNER][SLOT*W +: W];
        end

        xmw_wr_encode #(
            .W  (W),
            .NO (NO)
        ) u_enc (
            .din    (wr_data[k*W +: W]),
            .others (oth),
            .enc    (enc_data[k])
        );

        xmw_bank #(
            .W  (W),
            .AW (AW),
            .NT (NT)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en[k]),
            .waddr (wr_addr[k*AW +: AW]),
            .wdata (enc_data[k]),
            .taddr (tap_addr[k]),
            .tdata (tap_data[k])
        );
    end

    for (genvar j = 0; j < NR; j++) begin : g_read
        logic [NW*W-1:0] gath;

        for (genvar k = 0; k < NW; k++) begin : g_gath
            assign gath[k*W +: W] = tap_data[k][j*W +: W];
        end

        xmw_rd_decode #(
            .W  (W),
            .NB (NW)
        ) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (rd_en[j]),
            .taps  (gath),
            .q     (rd_data[j*W +: W])
        );
    end

endmodule

// File: rtl/xor_mwram_chk.sv
// Checker for xor_mwram: port-level timing properties of the read lanes.
module xor_mwram_chk #(
    parameter int NW = 2,
    parameter int NR = 2,
    parameter int W  = 8,
    parameter int AW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NW-1:0]    wr_en,
    input logic [NW*AW-1:0] wr_addr,
    input logic [NW*W-1:0]  wr_data,
    input logic [NR-1:0]    rd_en,
    input logic [NR*AW-1:0] rd_addr,
    input logic [NR*W-1:0]  rd_data
);
    localparam logic [NW-1:0] WE_ONE = 1;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_data == '0);

    for (genvar j = 0; j < NR; j++) begin : g_rp
        // R7
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en[j] |=> $stable(rd_data[j*W +: W]));

        // R8
        no_write_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && rd_en[j] && $past(rd_en[j]) && $past(wr_en) == '0
             && $past(rd_addr[j*AW +: AW]) == rd_addr[j*AW +: AW])
            |=> $stable(rd_data[j*W +: W]));

        for (genvar k = 0; k < NW; k++) begin : g_wp
            // R2
            write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && rd_en[j] && $past(wr_en) == (WE_ONE << k)
                 && $past(wr_addr[k*AW +: AW]) == rd_addr[j*AW +: AW])
                |=> rd_data[j*W +: W] == $past(wr_data[k*W +: W], 2));
        end
    end

endmodule

bind xor_mwram xor_mwram_chk #(
    .NW (NW),
    .NR (NR),
    .W  (W),
    .AW (AW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/xor_mwram_test.sv
`timescale 1ns/1ps
module xor_mwram_test;
    localparam int NW = 3;
    localparam int NR = 2;
    localparam int W  = 16;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW-1:0]         wr_en = '0;
    logic [NW-1:0][AW-1:0] wr_addr = '0;
    logic [NW-1:0][W-1:0]  wr_data = '0;
    logic [NR-1:0]         rd_en = '0;
    logic [NR-1:0][AW-1:0] rd_addr = '0;
    logic [NR*W-1:0]       rd_data;

    xor_mwram #(.NW(NW), .NR(NR), .W(W), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model
    logic [W-1:0] ref_mem [DEPTH];
    bit           ref_ok  [DEPTH];
    logic [W-1:0] out_model [NR];
    bit           out_ok    [NR];

    // Scoreboard queues
    int           q_port [$];
    logic [W-1:0] q_val  [$];
    int           q_due  [$];
    string        q_tag  [$];

    task automatic check(input string tag, input int port,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s port %0d actual %h expected %h", tag, port, act, exp);
        end
    endtask

    // Monitor: compare each lane when its expectation is due.
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            int p;
            p = q_port.pop_front();
            check(q_tag.pop_front(), p, rd_data[p*W +: W], q_val.pop_front());
            void'(q_due.pop_front());
        end
    end

    // Driver: one cycle of stimulus plus model update.
    task automatic step(input logic [NW-1:0] we, input logic [NW-1:0][AW-1:0] wa,
                        input logic [NW-1:0][W-1:0] wd, input logic [NR-1:0] re,
                        input logic [NR-1:0][AW-1:0] ra, input string tag);
        int hits [DEPTH];
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        for (int j = 0; j < NR; j++) begin
            if (re[j]) begin
                out_model[j] = ref_mem[ra[j]];
                out_ok[j] = ref_ok[ra[j]];
            end
            if (out_ok[j]) begin
                q_port.push_back(j); q_val.push_back(out_model[j]);
                q_due.push_back(cyc + 1); q_tag.push_back(tag);
            end
        end
        for (int a = 0; a < DEPTH; a++) hits[a] = 0;
        for (int k = 0; k < NW; k++) if (we[k]) hits[wa[k]]++;
        for (int k = 0; k < NW; k++) begin
            if (we[k]) begin
                ref_mem[wa[k]] = wd[k];
                ref_ok[wa[k]] = (hits[wa[k]] == 1);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0, '0, '0, "idle");
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = '0; rd_en = '0;
        q_port.delete(); q_val.delete(); q_due.delete(); q_tag.delete();
        for (int a = 0; a < DEPTH; a++) begin ref_mem[a] = '0; ref_ok[a] = 1; end
        for (int j = 0; j < NR; j++) begin out_model[j] = '0; out_ok[j] = 1; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < NR; j++) check(tag, j, rd_data[j*W +: W], '0);
    endtask

    task automatic wr1(input int k, input int a, input logic [W-1:0] d,
                       input logic [NR-1:0] re, input logic [NR-1:0][AW-1:0] ra,
                       input string tag);
        logic [NW-1:0] we;
        logic [NW-1:0][AW-1:0] wa;
        logic [NW-1:0][W-1:0] wd;
        we = '0; wa = '0; wd = '0;
        we[k] = 1'b1; wa[k] = AW'(a); wd[k] = d;
        step(we, wa, wd, re, ra, tag);
    endtask

    task automatic rd2(input int a0, input int a1, input string tag);
        logic [NR-1:0][AW-1:0] ra;
        ra = '0; ra[0] = AW'(a0); ra[1] = AW'(a1);
        step('0, '0, '0, 2'b11, ra, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0][AW-1:0] wa;
        logic [NW-1:0][W-1:0] wd;
        logic [NR-1:0][AW-1:0] ra;

        // R1: reset state and zero content
        do_reset("R1");
        rd2(0, DEPTH - 1, "R1");
        rd2(7, 9, "R1");

        // R2: single write, read on the following cycle
        wr1(0, 3, 16'hA5A5, '0, '0, "R2");
        rd2(3, 3, "R2");

        // R3: all writers at distinct addresses in one cycle
        wa[0] = 4'd1; wa[1] = 4'd2; wa[2] = 4'd4;
        wd[0] = 16'h1111; wd[1] = 16'h2222; wd[2] = 16'h4444;
        step(3'b111, wa, wd, '0, '0, "R3");
        rd2(1, 2, "R3");
        rd2(4, 1, "R3");

        // R4: different writers overwrite one address in turn
        wr1(1, 5, 16'h0B0B, '0, '0, "R4");
        wr1(0, 5, 16'h0C0C, '0, '0, "R4");
        rd2(5, 5, "R4");
        wr1(2, 5, 16'h0D0D, '0, '0, "R4");
        rd2(5, 2, "R4");

        // R5: read and write the same address in one cycle
        ra[0] = 4'd5; ra[1] = 4'd5;
        wr1(1, 5, 16'hEEEE, 2'b11, ra, "R5");
        rd2(5, 5, "R5");

        // R7: idle read port holds while its address changes
        ra[0] = 4'd5; ra[1] = 4'd1;
        wr1(0, 5, 16'h7777, 2'b01, '0, "R7");
        wr1(2, 1, 16'h7171, 2'b00, ra, "R7");
        wr1(1, 5, 16'h7272, 2'b00, ra, "R7");
        rd2(5, 1, "R7");

        // R8: disabled writers carry address and data but change nothing
        wa[0] = 4'd5; wa[1] = 4'd1; wa[2] = 4'd3;
        wd[0] = 16'hDEAD; wd[1] = 16'hBEEF; wd[2] = 16'hF00D;
        step('0, wa, wd, '0, '0, "R8");
        rd2(5, 1, "R8");
        rd2(3, 3, "R8");

        // R6: random non-conflicting traffic, independent read ports
        for (int i = 0; i < 400; i++) begin
            logic [NW-1:0] we;
            logic [NR-1:0] re;
            int base;
            base = int'($urandom % DEPTH);
            for (int k = 0; k < NW; k++) begin
                wa[k] = AW'((base + k * 5) % DEPTH);
                wd[k] = W'($urandom);
            end
            for (int j = 0; j < NR; j++) ra[j] = AW'($urandom % DEPTH);
            we = NW'($urandom);
            re = NR'($urandom);
            step(we, wa, wd, re, ra, "R6");
        end

        // R9: collision, then a single write restores the address
        wa[0] = 4'd7; wa[1] = 4'd7; wa[2] = 4'd8;
        wd[0] = 16'h1234; wd[1] = 16'h5678; wd[2] = 16'h8888;
        step(3'b111, wa, wd, '0, '0, "R9");
        rd2(8, 8, "R9");
        wr1(2, 7, 16'h9999, '0, '0, "R9");
        rd2(7, 7, "R9");
        wr1(0, 7, 16'h9A9A, '0, '0, "R9");
        rd2(7, 8, "R9");

        // R10: reset during operation clears stored content
        wr1(1, 12, 16'hCAFE, '0, '0, "R10");
        do_reset("R10");
        rd2(12, 7, "R10");
        rd2(5, 1, "R10");

        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule